// File: doc/BRIEF.md
# Fully Parallel Polar Code Encoder

This block turns a 32-bit information word into a 32-bit polar codeword in a single pass. The word is multiplied over GF(2) by the fifth Kronecker power of the two-by-two lower-triangular kernel. The product is computed by a butterfly network of five cascaded stages. Each stage applies sixteen kernel operations, each made from one XOR gate and one pass-through. The information word enters in natural bit order. The codeword leaves in bit-reversed index order.

The network is purely combinational and feeds one output register. A new word may be presented on every clock, and each accepted word appears exactly one cycle later together with a valid strobe. Because the block is small and exhaustive, it also serves as the golden reference against which area-reduced (folded) encoders of the same code length are compared.

Top module: `polar_enc_full`

## Requirements
- R1: For an accepted word u, the codeword is x = u·G over GF(2), where G is the 5-fold Kronecker power of [[1,0],[1,1]]; equivalently x_j is the XOR of every u_i whose index i has all the set bits of j.
- R2: Output bit k of `code_o` carries x_r, where r is k with its five index bits reversed (bit 0 of k becomes bit 4 of r).
- R3: `valid_o` in a cycle equals `valid_i` of the previous cycle when not in reset (one cycle latency).
- R4: When `valid_i` is low, `code_o` keeps its previous value whatever `data_i` holds.
- R5: A synchronous active-high `rst` clears `code_o` to zero and `valid_o` to 0 at the next clock edge.
- R6: Output bit 0 of an accepted word equals the XOR parity of all 32 input bits.
- R7: Output bit 31 of an accepted word equals input bit 31.
- R8: A word with a single one at index i gives a codeword with exactly 2^popcount(i) ones.
- R9: An all-zero word encodes to all zeros, and an all-ones word encodes to 32'h8000_0000 (only x_31 is odd).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Information word on `data_i` is accepted this cycle |
| data_i | input | 32 | Information word, natural bit order |
| valid_o | output | 1 | Codeword on `code_o` is new this cycle |
| code_o | output | 32 | Registered codeword, bit-reversed index order |

## Verification
Every one of the 32 single-one words is tried: each selects one row of the generator matrix, so a wrong butterfly span or a swapped kernel leg changes the ones count or their positions. The all-zero word and the all-ones word show that nothing is inverted, and that every output except bit 31 collects an even number of inputs. Random words, alternated with idle cycles that carry fresh junk data, separate a broken output hold and a wrong latency from a right codeword. They are compared on every clock against a matrix product written directly from the subset rule. A reset during the stream checks that the register clears.

// File: rtl/polar_enc_pkg.sv
package polar_enc_pkg;

    // Default code length exponent: N = 2**POLAR_LOG_N.
    localparam int unsigned POLAR_LOG_N = 5;

    // Reverse the lowest 'bits' bits of an index.
    function automatic int unsigned rev_index(input int unsigned idx, input int unsigned bits);
        int unsigned r;
        r = 0;
        for (int unsigned b = 0; b < bits; b++) begin
            if (((idx >> b) & 1) != 0) begin
                r = r | (1 << (bits - 1 - b));
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/polar_kernel_stage.sv
// One butterfly stage: every kernel pairs lines LO and LO+SPAN.
// The lower-index line gets the XOR, the higher-index line passes through.
module polar_kernel_stage #(
    parameter int unsigned LOG_N = 5,
    parameter int unsigned STAGE = 1
) (
    input  logic [(1 << LOG_N)-1:0] in_v,
    output logic [(1 << LOG_N)-1:0] out_v
);
    localparam int unsigned N     = 1 << LOG_N;
    localparam int unsigned SPAN  = 1 << (STAGE - 1);
    localparam int unsigned PAIRS = N / 2;

    for (genvar p = 0; p < PAIRS; p++) begin : g_kernel
        localparam int unsigned LO = ((p >> (STAGE - 1)) << STAGE) | (p & (SPAN - 1));
        localparam int unsigned HI = LO + SPAN;
        assign out_v[LO] = in_v[LO] ^ in_v[HI];
        assign out_v[HI] = in_v[HI];
    end
endmodule

// File: rtl/polar_bitrev_map.sv
// Pure wiring: output position k takes network line rev(k).
module polar_bitrev_map #(
    parameter int unsigned LOG_N = 5
) (
    input  logic [(1 << LOG_N)-1:0] nat_v,
    output logic [(1 << LOG_N)-1:0] rev_v
);
    localparam int unsigned N = 1 << LOG_N;

    for (genvar k = 0; k < N; k++) begin : g_wire
        localparam int unsigned SRC = polar_enc_pkg::rev_index(k, LOG_N);
        assign rev_v[k] = nat_v[SRC];
    end
endmodule

// File: rtl/polar_enc_full.sv
module polar_enc_full #(
    parameter int unsigned LOG_N = polar_enc_pkg::POLAR_LOG_N
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    valid_i,
    input  logic [(1 << LOG_N)-1:0] data_i,
    output logic                    valid_o,
    output logic [(1 << LOG_N)-1:0] code_o
);
    localparam int unsigned N = 1 << LOG_N;

    typedef logic [N-1:0] word_t;

    typedef struct packed {
        logic  vld;
        word_t code;
    } out_reg_t;

    // Line values between stages; line_w[0] is the raw input.
    word_t line_w [LOG_N+1];
    word_t mapped_w;

    assign line_w[0] = data_i;

    for (genvar s = 1; s <= LOG_N; s++) begin : g_stage
        polar_kernel_stage #(
            .LOG_N (LOG_N),
            .STAGE (s)
        ) u_stage (
            .in_v  (line_w[s-1]),
            .out_v (line_w[s])
        );
    end

    polar_bitrev_map #(
        .LOG_N (LOG_N)
    ) u_map (
        .nat_v (line_w[LOG_N]),
        .rev_v (mapped_w)
    );

    out_reg_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        out_d.vld = valid_i;
        if (valid_i) begin
            out_d.code = mapped_w;
        end
        if (rst) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign valid_o = out_q.vld;
    assign code_o  = out_q.code;
endmodule

// File: rtl/polar_enc_full_chk.sv
module polar_enc_full_chk #(
    parameter int unsigned LOG_N = polar_enc_pkg::POLAR_LOG_N
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    valid_i,
    input logic [(1 << LOG_N)-1:0] data_i,
    input logic                    valid_o,
    input logic [(1 << LOG_N)-1:0] code_o
);
    localparam int unsigned N = 1 << LOG_N;

    p_valid_follow_r3: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);

    p_valid_drop_r3: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o);

    p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(code_o));

    p_parity_bit_r6: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (code_o[0] == ^$past(data_i)));

    p_top_bit_r7: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (code_o[N-1] == $past(data_i[N-1])));

    p_zero_word_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_i && data_i == '0) |=> (code_o == '0));

    logic prev_rst_q = 1'b0;

    always_ff @(posedge clk) begin
        prev_rst_q <= rst;
    end

    always @(posedge clk) begin
        if (prev_rst_q) begin
            p_reset_clear_r5: assert (!valid_o && code_o == '0);
        end
    end
endmodule

bind polar_enc_full polar_enc_full_chk #(
    .LOG_N (LOG_N)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_i),
    .data_i  (data_i),
    .valid_o (valid_o),
    .code_o  (code_o)
);

// File: tb/tb_polar_enc_full.sv
`timescale 1ns/1ps
module tb_polar_enc_full;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          valid_i;
    logic [N-1:0]  data_i;
    logic          valid_o;
    logic [N-1:0]  code_o;

    int checks = 0;
    int errors = 0;

    // Reference state: what the outputs must show after the next edge.
    logic          exp_vld;
    logic [N-1:0]  exp_code;

    always #2.5 clk = ~clk;

    polar_enc_full dut (
        .clk     (clk),
        .rst     (rst),
        .valid_i (valid_i),
        .data_i  (data_i),
        .valid_o (valid_o),
        .code_o  (code_o)
    );

    // Subset rule, then bit-reversed placement (R1, R2).
    function automatic logic [N-1:0] ref_encode(input logic [N-1:0] u);
        logic [N-1:0] x;
        logic [N-1:0] y;
        x = '0;
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                if ((i & j) == j) x[j] = x[j] ^ u[i];
            end
        end
        for (int k = 0; k < N; k++) begin
            int r = 0;
            for (int b = 0; b < 5; b++) begin
                if (k[b]) r = r | (1 << (4 - b));
            end
            y[k] = x[r];
        end
        return y;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one cycle, let one rising edge pass, compare at the falling edge.
    task automatic step(input logic v, input logic [N-1:0] d);
        valid_i = v;
        data_i  = d;
        if (rst) begin
            exp_vld  = 1'b0;
            exp_code = '0;
        end else begin
            exp_vld = v;
            if (v) exp_code = ref_encode(d);
        end
        @(negedge clk);
        check(valid_o == exp_vld, "R3 valid latency", {31'b0, valid_o}, {31'b0, exp_vld});
        check(code_o == exp_code, v ? "R1/R2 codeword" : "R4 hold when idle",
              code_o, exp_code);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst     = 1'b1;
        valid_i = 1'b0;
        data_i  = '0;
        exp_vld = 1'b0;
        exp_code = '0;
        repeat (3) @(negedge clk);
        // R5 reset state
        check(valid_o == 1'b0, "R5 reset valid", {31'b0, valid_o}, '0);
        check(code_o == '0, "R5 reset code", code_o, '0);
        rst = 1'b0;

        // R9 all-zero and all-ones
        step(1'b1, '0);
        check(code_o == '0, "R9 all-zero", code_o, '0);
        step(1'b1, '1);
        check(code_o == 32'h8000_0000, "R9 all-ones", code_o, 32'h8000_0000);

        // R8 single-one words, one generator row each
        for (int i = 0; i < N; i++) begin
            int ones;
            step(1'b1, 32'(1) << i);
            ones = $countones(code_o);
            check(ones == (1 << $countones(i)), "R8 single-one weight",
                  32'(ones), 32'(1 << $countones(i)));
        end

        // Random words with idle cycles carrying junk (R1, R4, R6, R7)
        for (int t = 0; t < 200; t++) begin
            logic [N-1:0] w;
            w = $urandom;
            step(1'b1, w);
            check(code_o[0] == ^w, "R6 parity bit", {31'b0, code_o[0]}, {31'b0, ^w});
            check(code_o[N-1] == w[N-1], "R7 top bit", {31'b0, code_o[N-1]},
                  {31'b0, w[N-1]});
            if ((t % 3) == 0) step(1'b0, $urandom);
        end

        // Back-to-back words
        for (int t = 0; t < 20; t++) step(1'b1, $urandom);

        // Reset in the middle of the stream (R5)
        rst = 1'b1;
        step(1'b1, $urandom);
        check(valid_o == 1'b0 && code_o == '0, "R5 mid-stream reset", code_o, '0);
        rst = 1'b0;
        step(1'b0, $urandom);
        step(1'b1, 32'hDEAD_BEEF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule